// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit maps a 32-bit effective address onto a physical page address through a small set of block translation entries. There are two independent sets of entries. One serves instruction fetches and the other serves every other access. Each entry is a pair of 32-bit words. The upper word holds the address tag, a block-length mask and two privilege-valid bits. The lower word holds the physical base and the access rights.

A request presents an address, the privilege level and the fetch/data select. One clock later the unit returns a response strobe with four results: a hit flag, the physical page address, and the read and write permissions. These come from the lowest-numbered entry that both matches the address and is valid for the current privilege. The entries are loaded through a single-word write port. Each write picks a side, an entry index and one of the two words.

Top module: `blk_xlate_match`

## Requirements
- R1: Effective-address bits 31:28 must equal upper-word bits 31:28 exactly for an entry to match.
- R2: The block-length mask is upper-word bits 12:2, aligned onto address bits 27:17. Effective-address bits 27:17 are compared with upper-word bits 27:17 only where the mask bit is 0.
- R3: An entry qualifies in supervisor mode (`req_user`=0) only if upper-word bit 1 is set. It qualifies in user mode (`req_user`=1) only if upper-word bit 0 is set.
- R4: On a hit, the physical address is built in four parts:
  - bits 31:28 are lower-word bits 31:28;
  - bits 27:17 are the OR of lower-word bits 27:17 with the effective-address bits that the block-length mask selects;
  - bits 16:12 are copied from the effective address;
  - bits 11:0 are zero.
- R5: Permissions on a hit come from the lower word:
  - bit 1 set grants read and write;
  - otherwise, bit 0 set grants read only;
  - with neither bit set, no access is granted and the hit flag is still raised.
- R6: When several entries qualify, the lowest index (0 first) supplies the result.
- R7: A request with `req_fetch`=1 uses the instruction set (`wr_side`=1). A request with `req_fetch`=0 uses the data set (`wr_side`=0).
- R8: When no entry qualifies, `rsp_hit`, `rsp_paddr`, `rsp_rd_ok` and `rsp_wr_ok` are all zero.
- R9: The write port stores `wr_data` into the upper word (`wr_upper`=1) or the lower word (`wr_upper`=0) of entry `wr_idx` on side `wr_side`. All words reset to zero, so every entry starts invalid. A write takes effect for requests issued from the following cycle onward.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The response fields are zero when `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Effective address |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| wr_en | input | 1 | Entry word write strobe |
| wr_side | input | 1 | 1 = instruction set, 0 = data set |
| wr_idx | input | 2 | Entry index |
| wr_upper | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A qualifying entry matched |
| rsp_paddr | output | 32 | Physical page address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |

## Verification
A register write and a lookup can land in the same cycle, and both can target the very entry that will supply the result. The bench issues a fetch lookup in the same cycle as it rewrites the lower word of the matching instruction entry. The response must carry the old physical base and rights. A lookup issued one cycle later must carry the new ones. The bench also checks the data side against the instruction side, to show that a write to one side leaves the other unchanged.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
    localparam int ADDR_W   = 32;
    localparam int TAG_HI   = 31;
    localparam int TAG_MID  = 28;
    localparam int BLK_HI   = 27;
    localparam int BLK_LO   = 17;
    localparam int BLK_W    = BLK_HI - BLK_LO + 1;
    localparam int PG_HI    = 16;
    localparam int PG_LO    = 12;
    localparam int LEN_HI   = 12;
    localparam int LEN_LO   = 2;
    localparam int SIDES    = 2;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] paddr;
        logic              rd_ok;
        logic              wr_ok;
    } bxm_result_t;
endpackage

// File: rtl/bxm_regfile.sv
module bxm_regfile
    import bxm_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_side,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic                            wr_upper,
    input  logic [ADDR_W-1:0]               wr_data,
    input  logic                            rd_side,
    output logic [NUM_ENT-1:0][ADDR_W-1:0]  upr_o,
    output logic [NUM_ENT-1:0][ADDR_W-1:0]  lwr_o
);
    typedef struct packed {
        logic [SIDES-1:0][NUM_ENT-1:0][ADDR_W-1:0] upr;
        logic [SIDES-1:0][NUM_ENT-1:0][ADDR_W-1:0] lwr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int s = 0; s < SIDES; s++) begin
            for (int e = 0; e < NUM_ENT; e++) begin
                if (wr_en && (int'(wr_side) == s) && (int'(wr_idx) == e)) begin
                    if (wr_upper) regs_d.upr[s][e] = wr_data;
                    else          regs_d.lwr[s][e] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign upr_o = regs_q.upr[rd_side];
    assign lwr_o = regs_q.lwr[rd_side];
endmodule

// File: rtl/bxm_entry_cmp.sv
module bxm_entry_cmp
    import bxm_pkg::*;
(
    input  logic [ADDR_W-1:0] ea,
    input  logic              user,
    input  logic [ADDR_W-1:0] upr,
    input  logic [ADDR_W-1:0] lwr,
    output bxm_result_t       res
);
    logic [BLK_W-1:0] len_mask;
    logic             hi_eq;
    logic             mid_eq;
    logic             priv_ok;
    logic             unused_bits;

    assign len_mask = upr[LEN_HI:LEN_LO];
    assign hi_eq    = (ea[TAG_HI:TAG_MID] == upr[TAG_HI:TAG_MID]);
    assign mid_eq   = ((ea[BLK_HI:BLK_LO] & ~len_mask) == upr[BLK_HI:BLK_LO]);
    assign priv_ok  = user ? upr[0] : upr[1];

    always_comb begin
        res.hit   = hi_eq && mid_eq && priv_ok;
        res.paddr = {lwr[TAG_HI:TAG_MID],
                     (ea[BLK_HI:BLK_LO] & len_mask) | lwr[BLK_HI:BLK_LO],
                     ea[PG_HI:PG_LO],
                     {PG_LO{1'b0}}};
        res.wr_ok = lwr[1];
        res.rd_ok = lwr[1] | lwr[0];
    end

    assign unused_bits = ^{upr[PG_HI:LEN_HI+1], lwr[PG_HI:2], ea[PG_LO-1:0]};
endmodule

// File: rtl/bxm_prio_sel.sv
module bxm_prio_sel
    import bxm_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  bxm_result_t [NUM_ENT-1:0] cand,
    output bxm_result_t               win
);
    always_comb begin
        win = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (cand[i].hit) win = cand[i];
        end
    end
endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
    import bxm_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_user,
    input  logic              req_fetch,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_upper,
    input  logic [31:0]       wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok
);
    typedef struct packed {
        logic        valid;
        bxm_result_t res;
    } out_t;

    logic [NUM_ENT-1:0][ADDR_W-1:0] upr_sel;
    logic [NUM_ENT-1:0][ADDR_W-1:0] lwr_sel;
    bxm_result_t [NUM_ENT-1:0]      cand;
    bxm_result_t                    win;
    out_t                           out_d, out_q;

    bxm_regfile #(.NUM_ENT(NUM_ENT)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_side  (wr_side),
        .wr_idx   (wr_idx),
        .wr_upper (wr_upper),
        .wr_data  (wr_data),
        .rd_side  (req_fetch),
        .upr_o    (upr_sel),
        .lwr_o    (lwr_sel)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        bxm_entry_cmp cmp_i (
            .ea   (req_addr),
            .user (req_user),
            .upr  (upr_sel[g]),
            .lwr  (lwr_sel[g]),
            .res  (cand[g])
        );
    end

    bxm_prio_sel #(.NUM_ENT(NUM_ENT)) sel_i (
        .cand (cand),
        .win  (win)
    );

    always_comb begin
        out_d       = '0;
        out_d.valid = req_valid;
        if (req_valid) out_d.res = win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid = out_q.valid;
    assign rsp_hit   = out_q.res.hit;
    assign rsp_paddr = out_q.res.paddr;
    assign rsp_rd_ok = out_q.res.rd_ok;
    assign rsp_wr_ok = out_q.res.wr_ok;
endmodule

// File: rtl/bxm_chk.sv
module bxm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_paddr,
    input logic        rsp_rd_ok,
    input logic        rsp_wr_ok
);
    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == 32'h0 && !rsp_rd_ok && !rsp_wr_ok));
    p_write_has_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ok |-> rsp_rd_ok);
    p_page_offset_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_paddr[11:0] == 12'h0);
    p_page_bits_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> rsp_paddr[16:12] == $past(req_addr[16:12]));
endmodule

bind blk_xlate_match bxm_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_rd_ok (rsp_rd_ok),
    .rsp_wr_ok (rsp_wr_ok)
);

// File: tb/blk_xlate_match_tb_top.sv
module blk_xlate_match_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_user = 1'b0;
    logic        req_fetch = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_side = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_upper = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid, rsp_hit, rsp_rd_ok, rsp_wr_ok;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    blk_xlate_match dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_user(req_user),
        .req_fetch(req_fetch), .wr_en(wr_en), .wr_side(wr_side),
        .wr_idx(wr_idx), .wr_upper(wr_upper), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic side, input logic [1:0] idx, input logic up,
                           input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_idx = idx; wr_upper = up; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issues one lookup and checks the response one cycle later.
    task automatic look(input string req, input logic [31:0] addr, input logic user,
                        input logic fetch, input logic hit, input logic [31:0] pa,
                        input logic rd, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_user = user; req_fetch = fetch;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " hit"},   32'(rsp_hit), 32'(hit));
        chk({req, " paddr"}, rsp_paddr, pa);
        chk({req, " rd"},    32'(rsp_rd_ok), 32'(rd));
        chk({req, " wr"},    32'(rsp_wr_ok), 32'(wr));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10 reset valid", 32'(rsp_valid), 32'd0);
        look("R9 reset entries invalid", 32'h1000_2000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        look("R8 reset fetch miss", 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_basic;
        wr_word(1'b0, 2'd0, 1'b1, 32'h1000_0002);
        wr_word(1'b0, 2'd0, 1'b0, 32'h8000_0002);
        look("R4 R5 basic hit", 32'h1001_5ABC, 1'b0, 1'b0, 1'b1, 32'h8001_5000, 1'b1, 1'b1);
        look("R1 top tag mismatch", 32'h2001_5ABC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_mask;
        wr_word(1'b0, 2'd1, 1'b1, 32'h3000_003E);
        wr_word(1'b0, 2'd1, 1'b0, 32'h4060_0001);
        look("R2 R4 masked bits pass", 32'h301E_7123, 1'b0, 1'b0, 1'b1, 32'h407E_7000, 1'b1, 1'b0);
        look("R2 unmasked bit compared", 32'h3020_0000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_priv;
        look("R3 supervisor-only entry user miss", 32'h3000_1000, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        wr_word(1'b0, 2'd2, 1'b1, 32'h3000_0001);
        wr_word(1'b0, 2'd2, 1'b0, 32'h5000_0000);
        look("R3 R5 user entry no access", 32'h3000_1000, 1'b1, 1'b0, 1'b1, 32'h5000_1000, 1'b0, 1'b0);
        look("R6 supervisor lower index", 32'h3000_1000, 1'b0, 1'b0, 1'b1, 32'h4060_1000, 1'b1, 1'b0);
    endtask

    task automatic t_prio;
        wr_word(1'b0, 2'd3, 1'b1, 32'h1000_0003);
        wr_word(1'b0, 2'd3, 1'b0, 32'h9000_0001);
        look("R6 entry0 wins", 32'h1000_2000, 1'b0, 1'b0, 1'b1, 32'h8000_2000, 1'b1, 1'b1);
        look("R6 R3 user skips entry0", 32'h1000_2000, 1'b1, 1'b0, 1'b1, 32'h9000_2000, 1'b1, 1'b0);
    endtask

    task automatic t_side;
        look("R7 fetch side empty", 32'h1000_2000, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
        wr_word(1'b1, 2'd0, 1'b1, 32'h1000_0002);
        wr_word(1'b1, 2'd0, 1'b0, 32'hA000_0001);
        look("R7 fetch side hit", 32'h1000_2000, 1'b0, 1'b1, 1'b1, 32'hA000_2000, 1'b1, 1'b0);
        look("R7 data side unchanged", 32'h1000_2000, 1'b0, 1'b0, 1'b1, 32'h8000_2000, 1'b1, 1'b1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_side = 1'b1; wr_idx = 2'd0; wr_upper = 1'b0; wr_data = 32'hB000_0002;
        req_valid = 1'b1; req_addr = 32'h1000_2000; req_user = 1'b0; req_fetch = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R9 same-cycle old hit", 32'(rsp_hit), 32'd1);
        chk("R9 same-cycle old paddr", rsp_paddr, 32'hA000_2000);
        chk("R9 same-cycle old wr", 32'(rsp_wr_ok), 32'd0);
        @(negedge clk);
        chk("R10 idle no valid", 32'(rsp_valid), 32'd0);
        chk("R10 idle fields zero", rsp_paddr, 32'h0);
        look("R9 new word visible", 32'h1000_2000, 1'b0, 1'b1, 1'b1, 32'hB000_2000, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_mask();
        t_priv();
        t_prio();
        t_side();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule